// File: doc/BRIEF.md
# System Clock Source Selection Controller

This block decides which clock source drives the system clock and whether the PLL sits in the path. It holds two selection registers: one governs run and sleep operation, the other governs deep sleep. Each register carries a PLL-use bit, a direct-source code, a PLL-reference code and a divisor. A write to either register is validated first. A legal write is stored. An illegal write is dropped and raises a sticky error flag.

The block switches the live selection to the register chosen by the current power mode. It only switches on a divided-clock enable boundary. When the PLL path is requested, it keeps the previous source until the PLL reports lock. It drives a one-hot clock-select vector, a divided clock-enable, the enables for the switchable oscillators and the PLL, and a one-cycle pulse whenever a switch completes.

Top module: `sysclk_select`

## Requirements
- R1: After reset the live selection is the precision internal oscillator (code 0) with no PLL and divisor 0. The precision and low-frequency internal oscillators are enabled. The main oscillator, the RTC oscillator and the PLL are disabled. `clk_en` is high every cycle and `cfg_err` is low.
- R2: With the PLL-use bit at 0, the direct-source code selects the clock: 0 is the precision internal oscillator, 2 the low-frequency internal oscillator, 3 the main oscillator and 4 the RTC oscillator. `clk_sel` is one-hot with bit 0 for precision, bit 1 for low-frequency, bit 2 for main, bit 3 for RTC and bit 4 for the PLL.
- R3: With the PLL-use bit at 1, only reference codes 0 (precision) and 3 (main) are accepted. Codes 2 and 4, and every other code, are rejected, so the low-frequency and RTC oscillators never feed the PLL. While the PLL is live, `active_src` reports the reference code and `active_pll` is 1.
- R4: A write with an unlisted direct-source code (1, 5, 6, 7) or a rejected PLL-reference code sets `cfg_err` and leaves the stored selection, and therefore the live clock, unchanged.
- R5: A selection that uses the PLL is not made live until `pll_lock` is high at a clock-enable boundary. Until then the previous source stays live.
- R6: A change of source, PLL use or divisor takes effect only at a clock edge where `clk_en` is high. `switch_done` is high for exactly the one cycle after that edge, and the divider restarts its count.
- R7: While `deep_sleep` is 0 the run/sleep register is the target. While it is 1 the deep-sleep register is the target. Writes to the register that is not the target do not change the live clock.
- R8: With live divisor N, `clk_en` is high once every N+1 cycles. With N = 0 it is high every cycle.
- R9: The precision and low-frequency internal oscillators are always enabled. `mosc_en`, `rtc_en` and `pll_en` are high exactly while the live or the target selection uses that source, whether directly or as a PLL reference.
- R10: `cfg_err` stays high after being set, including across later legal writes, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| run_wr | input | 1 | Write strobe for the run/sleep register |
| run_use_pll | input | 1 | Run/sleep: route through the PLL |
| run_osc_src | input | 3 | Run/sleep: direct source code |
| run_pll_src | input | 3 | Run/sleep: PLL reference code |
| run_div | input | DIV_W | Run/sleep: divisor N (divide by N+1) |
| deep_wr | input | 1 | Write strobe for the deep-sleep register |
| deep_use_pll | input | 1 | Deep sleep: route through the PLL |
| deep_osc_src | input | 3 | Deep sleep: direct source code |
| deep_pll_src | input | 3 | Deep sleep: PLL reference code |
| deep_div | input | DIV_W | Deep sleep: divisor N |
| deep_sleep | input | 1 | 1 while the system is in deep sleep |
| pll_lock | input | 1 | PLL reports lock |
| clk_sel | output | 5 | One-hot live clock select |
| clk_en | output | 1 | Divided clock-enable |
| active_src | output | 3 | Live source code (PLL reference when the PLL is live) |
| active_pll | output | 1 | PLL path is live |
| switch_done | output | 1 | One-cycle pulse after a completed switch |
| cfg_err | output | 1 | Sticky rejected-write flag |
| piosc_en | output | 1 | Precision internal oscillator enable |
| lfiosc_en | output | 1 | Low-frequency internal oscillator enable |
| mosc_en | output | 1 | Main oscillator enable |
| rtc_en | output | 1 | RTC oscillator enable |
| pll_en | output | 1 | PLL enable |

## Verification
The hardest case to reach is a pending switch that waits on two conditions at once: the PLL has not locked yet, and a large divisor spaces the enable boundaries far apart. The mode input can also flip the target while that switch is still pending. The stimulus reaches this state by first making a divided source live. It then requests a PLL selection with lock held low and checks that the enables rise while the old source persists. Next it raises lock, so the switch must wait for the following boundary. It repeats the same sequence through the deep-sleep register by toggling the mode input around those writes.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;

    typedef enum logic [2:0] {
        SRC_PIOSC  = 3'd0,
        SRC_LFIOSC = 3'd2,
        SRC_MOSC   = 3'd3,
        SRC_RTC    = 3'd4
    } src_e;

    localparam int SEL_W       = 5;
    localparam int SEL_PLL_BIT = 4;

    typedef struct packed {
        logic use_pll;
        src_e src;
    } sel_t;

    localparam sel_t SEL_RESET = '{use_pll: 1'b0, src: SRC_PIOSC};

    function automatic logic osc_code_ok(input logic [2:0] code);
        logic ok;
        case (code)
            3'd0, 3'd2, 3'd3, 3'd4: ok = 1'b1;
            default:                ok = 1'b0;
        endcase
        return ok;
    endfunction

    function automatic logic pll_code_ok(input logic [2:0] code);
        logic ok;
        case (code)
            3'd0, 3'd3: ok = 1'b1;
            default:    ok = 1'b0;
        endcase
        return ok;
    endfunction

    function automatic logic cfg_ok(input logic use_pll,
                                    input logic [2:0] osc,
                                    input logic [2:0] pll);
        return use_pll ? pll_code_ok(pll) : osc_code_ok(osc);
    endfunction

    function automatic sel_t cfg_to_sel(input logic use_pll,
                                        input logic [2:0] osc,
                                        input logic [2:0] pll);
        sel_t s;
        s.use_pll = use_pll;
        s.src     = src_e'(use_pll ? pll : osc);
        return s;
    endfunction

    function automatic logic [SEL_W-1:0] sel_onehot(input sel_t s);
        logic [SEL_W-1:0] v;
        v = '0;
        if (s.use_pll) begin
            v[SEL_PLL_BIT] = 1'b1;
        end else begin
            case (s.src)
                SRC_PIOSC:  v[0] = 1'b1;
                SRC_LFIOSC: v[1] = 1'b1;
                SRC_MOSC:   v[2] = 1'b1;
                SRC_RTC:    v[3] = 1'b1;
                default:    v    = '0;
            endcase
        end
        return v;
    endfunction

    function automatic logic needs_src(input sel_t s, input src_e code);
        return s.src == code;
    endfunction

endpackage

// File: rtl/sysclk_cfg_slot.sv
module sysclk_cfg_slot
    import sysclk_pkg::*;
#(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic             wr_use_pll,
    input  logic [2:0]       wr_osc,
    input  logic [2:0]       wr_pll,
    input  logic [DIV_W-1:0] wr_div,
    output sel_t             sel,
    output logic [DIV_W-1:0] div,
    output logic             reject
);

    logic legal;

    assign legal  = cfg_ok(wr_use_pll, wr_osc, wr_pll);
    assign reject = wr && !legal;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel <= SEL_RESET;
            div <= '0;
        end else if (wr && legal) begin
            sel <= cfg_to_sel(wr_use_pll, wr_osc, wr_pll);
            div <= wr_div;
        end
    end

endmodule

// File: rtl/sysclk_divider.sv
module sysclk_divider #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             ce
);

    logic [DIV_W-1:0] cnt;

    assign ce = (cnt == div);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (restart || ce) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/sysclk_switcher.sv
module sysclk_switcher
    import sysclk_pkg::*;
#(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  sel_t             tgt_sel,
    input  logic [DIV_W-1:0] tgt_div,
    input  logic             ce,
    input  logic             pll_lock,
    output sel_t             act_sel,
    output logic [DIV_W-1:0] act_div,
    output logic             go,
    output logic             done
);

    logic differs;
    logic ready;

    assign differs = (tgt_sel != act_sel) || (tgt_div != act_div);
    assign ready   = !tgt_sel.use_pll || pll_lock;
    assign go      = differs && ready && ce;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_sel <= SEL_RESET;
            act_div <= '0;
            done    <= 1'b0;
        end else begin
            done <= go;
            if (go) begin
                act_sel <= tgt_sel;
                act_div <= tgt_div;
            end
        end
    end

endmodule

// File: rtl/sysclk_enables.sv
module sysclk_enables
    import sysclk_pkg::*;
(
    input  sel_t act_sel,
    input  sel_t tgt_sel,
    output logic piosc_en,
    output logic lfiosc_en,
    output logic mosc_en,
    output logic rtc_en,
    output logic pll_en
);

    assign piosc_en  = 1'b1;
    assign lfiosc_en = 1'b1;
    assign mosc_en   = needs_src(act_sel, SRC_MOSC) || needs_src(tgt_sel, SRC_MOSC);
    assign rtc_en    = needs_src(act_sel, SRC_RTC)  || needs_src(tgt_sel, SRC_RTC);
    assign pll_en    = act_sel.use_pll || tgt_sel.use_pll;

endmodule

// File: rtl/sysclk_select.sv
module sysclk_select
    import sysclk_pkg::*;
#(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_wr,
    input  logic             run_use_pll,
    input  logic [2:0]       run_osc_src,
    input  logic [2:0]       run_pll_src,
    input  logic [DIV_W-1:0] run_div,
    input  logic             deep_wr,
    input  logic             deep_use_pll,
    input  logic [2:0]       deep_osc_src,
    input  logic [2:0]       deep_pll_src,
    input  logic [DIV_W-1:0] deep_div,
    input  logic             deep_sleep,
    input  logic             pll_lock,
    output logic [4:0]       clk_sel,
    output logic             clk_en,
    output logic [2:0]       active_src,
    output logic             active_pll,
    output logic             switch_done,
    output logic             cfg_err,
    output logic             piosc_en,
    output logic             lfiosc_en,
    output logic             mosc_en,
    output logic             rtc_en,
    output logic             pll_en
);

    localparam int NSLOT     = 2;
    localparam int SLOT_RUN  = 0;
    localparam int SLOT_DEEP = 1;

    logic             slot_wr      [NSLOT];
    logic             slot_use_pll [NSLOT];
    logic [2:0]       slot_osc     [NSLOT];
    logic [2:0]       slot_pll     [NSLOT];
    logic [DIV_W-1:0] slot_wdiv    [NSLOT];
    sel_t             slot_sel     [NSLOT];
    logic [DIV_W-1:0] slot_div     [NSLOT];
    logic             slot_reject  [NSLOT];

    assign slot_wr[SLOT_RUN]       = run_wr;
    assign slot_use_pll[SLOT_RUN]  = run_use_pll;
    assign slot_osc[SLOT_RUN]      = run_osc_src;
    assign slot_pll[SLOT_RUN]      = run_pll_src;
    assign slot_wdiv[SLOT_RUN]     = run_div;
    assign slot_wr[SLOT_DEEP]      = deep_wr;
    assign slot_use_pll[SLOT_DEEP] = deep_use_pll;
    assign slot_osc[SLOT_DEEP]     = deep_osc_src;
    assign slot_pll[SLOT_DEEP]     = deep_pll_src;
    assign slot_wdiv[SLOT_DEEP]    = deep_div;

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        sysclk_cfg_slot #(.DIV_W(DIV_W)) u_slot (
            .clk        (clk),
            .rst        (rst),
            .wr         (slot_wr[g]),
            .wr_use_pll (slot_use_pll[g]),
            .wr_osc     (slot_osc[g]),
            .wr_pll     (slot_pll[g]),
            .wr_div     (slot_wdiv[g]),
            .sel        (slot_sel[g]),
            .div        (slot_div[g]),
            .reject     (slot_reject[g])
        );
    end

    logic any_reject;
    always_comb begin
        any_reject = 1'b0;
        for (int i = 0; i < NSLOT; i++) begin
            any_reject = any_reject | slot_reject[i];
        end
    end

    logic err_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else if (any_reject) begin
            err_q <= 1'b1;
        end
    end

    sel_t             tgt_sel;
    logic [DIV_W-1:0] tgt_div;
    assign tgt_sel = deep_sleep ? slot_sel[SLOT_DEEP] : slot_sel[SLOT_RUN];
    assign tgt_div = deep_sleep ? slot_div[SLOT_DEEP] : slot_div[SLOT_RUN];

    sel_t             act_sel;
    logic [DIV_W-1:0] act_div;
    logic             ce;
    logic             go;
    logic             done;

    sysclk_switcher #(.DIV_W(DIV_W)) u_switch (
        .clk      (clk),
        .rst      (rst),
        .tgt_sel  (tgt_sel),
        .tgt_div  (tgt_div),
        .ce       (ce),
        .pll_lock (pll_lock),
        .act_sel  (act_sel),
        .act_div  (act_div),
        .go       (go),
        .done     (done)
    );

    sysclk_divider #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .restart (go),
        .div     (act_div),
        .ce      (ce)
    );

    sysclk_enables u_en (
        .act_sel   (act_sel),
        .tgt_sel   (tgt_sel),
        .piosc_en  (piosc_en),
        .lfiosc_en (lfiosc_en),
        .mosc_en   (mosc_en),
        .rtc_en    (rtc_en),
        .pll_en    (pll_en)
    );

    assign clk_sel     = sel_onehot(act_sel);
    assign clk_en      = ce;
    assign active_src  = act_sel.src;
    assign active_pll  = act_sel.use_pll;
    assign switch_done = done;
    assign cfg_err     = err_q;

endmodule

// File: rtl/sysclk_select_chk.sv
module sysclk_select_chk #(
    parameter int DIV_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic [4:0]       clk_sel,
    input logic             clk_en,
    input logic [2:0]       active_src,
    input logic             active_pll,
    input logic             switch_done,
    input logic             cfg_err,
    input logic             piosc_en,
    input logic             lfiosc_en,
    input logic             pll_en,
    input logic             pll_lock,
    input logic [DIV_W-1:0] act_div
);

    assert_sel_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $countones(clk_sel) == 1);

    assert_ref_legal_R3: assert property (@(posedge clk) disable iff (rst)
        active_pll |-> (active_src == 3'd0 || active_src == 3'd3));

    assert_lock_before_pll_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(active_pll) |-> $past(pll_lock));

    assert_switch_on_boundary_R6: assert property (@(posedge clk) disable iff (rst)
        switch_done |-> $past(clk_en));

    assert_src_change_pulses_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(active_src) |-> switch_done);

    assert_undivided_R8: assert property (@(posedge clk) disable iff (rst)
        (act_div == '0) |-> clk_en);

    assert_internal_on_R9: assert property (@(posedge clk) disable iff (rst)
        piosc_en && lfiosc_en);

    assert_pll_powered_R9: assert property (@(posedge clk) disable iff (rst)
        active_pll |-> pll_en);

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> cfg_err);

endmodule

bind sysclk_select sysclk_select_chk #(.DIV_W(DIV_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .clk_sel     (clk_sel),
    .clk_en      (clk_en),
    .active_src  (active_src),
    .active_pll  (active_pll),
    .switch_done (switch_done),
    .cfg_err     (cfg_err),
    .piosc_en    (piosc_en),
    .lfiosc_en   (lfiosc_en),
    .pll_en      (pll_en),
    .pll_lock    (pll_lock),
    .act_div     (act_div)
);

// File: tb/tb_sysclk_select.sv
module tb_sysclk_select;
    localparam int DIV_W = 6;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             run_wr = 1'b0, run_use_pll = 1'b0;
    logic [2:0]       run_osc_src = '0, run_pll_src = '0;
    logic [DIV_W-1:0] run_div = '0;
    logic             deep_wr = 1'b0, deep_use_pll = 1'b0;
    logic [2:0]       deep_osc_src = '0, deep_pll_src = '0;
    logic [DIV_W-1:0] deep_div = '0;
    logic             deep_sleep = 1'b0, pll_lock = 1'b0;
    logic [4:0]       clk_sel;
    logic             clk_en, active_pll, switch_done, cfg_err;
    logic [2:0]       active_src;
    logic             piosc_en, lfiosc_en, mosc_en, rtc_en, pll_en;

    always #2 clk = ~clk;

    sysclk_select #(.DIV_W(DIV_W)) dut (.*);

    int n_checks = 0;
    int n_errors = 0;
    bit started  = 1'b0;

    // Reference model state
    int m_run_pll, m_run_src, m_run_div;
    int m_dp_pll, m_dp_src, m_dp_div;
    int m_act_pll, m_act_src, m_act_div, m_cnt;
    bit m_done, m_err;

    function automatic bit legal(int p, int osc, int ref_code);
        if (p != 0) return (ref_code == 0 || ref_code == 3);
        return (osc == 0 || osc == 2 || osc == 3 || osc == 4);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_run_pll = 0; m_run_src = 0; m_run_div = 0;
            m_dp_pll = 0;  m_dp_src = 0;  m_dp_div = 0;
            m_act_pll = 0; m_act_src = 0; m_act_div = 0;
            m_cnt = 0; m_done = 0; m_err = 0;
        end else begin
            int tp, ts, td;
            bit ce, go;
            tp = deep_sleep ? m_dp_pll : m_run_pll;
            ts = deep_sleep ? m_dp_src : m_run_src;
            td = deep_sleep ? m_dp_div : m_run_div;
            ce = (m_cnt == m_act_div);
            go = ce && (tp != m_act_pll || ts != m_act_src || td != m_act_div)
                 && (tp == 0 || pll_lock);
            m_done = go;
            if (go) begin
                m_act_pll = tp; m_act_src = ts; m_act_div = td; m_cnt = 0;
            end else if (ce) m_cnt = 0;
            else m_cnt = m_cnt + 1;
            if (run_wr) begin
                if (legal(run_use_pll, run_osc_src, run_pll_src)) begin
                    m_run_pll = run_use_pll;
                    m_run_src = run_use_pll ? run_pll_src : run_osc_src;
                    m_run_div = run_div;
                end else m_err = 1;
            end
            if (deep_wr) begin
                if (legal(deep_use_pll, deep_osc_src, deep_pll_src)) begin
                    m_dp_pll = deep_use_pll;
                    m_dp_src = deep_use_pll ? deep_pll_src : deep_osc_src;
                    m_dp_div = deep_div;
                end else m_err = 1;
            end
        end
    end

    task automatic chk(string tag, int actual, int expected);
        n_checks++;
        if (actual !== expected) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, actual, expected, $time);
        end
    endtask

    function automatic int exp_sel();
        if (m_act_pll != 0) return 16;
        case (m_act_src)
            0: return 1;
            2: return 2;
            3: return 4;
            4: return 8;
            default: return 0;
        endcase
    endfunction

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (started && !rst) begin
            int ts, tp;
            tp = deep_sleep ? m_dp_pll : m_run_pll;
            ts = deep_sleep ? m_dp_src : m_run_src;
            chk("R2 clk_sel", int'(clk_sel), exp_sel());
            chk("R2 active_src", int'(active_src), m_act_src);
            chk("R3 active_pll", int'(active_pll), m_act_pll);
            chk("R8 clk_en", int'(clk_en), int'(m_cnt == m_act_div));
            chk("R6 switch_done", int'(switch_done), int'(m_done));
            chk("R4 cfg_err", int'(cfg_err), int'(m_err));
            chk("R9 mosc_en", int'(mosc_en), int'(m_act_src == 3 || ts == 3));
            chk("R9 rtc_en", int'(rtc_en), int'(m_act_src == 4 || ts == 4));
            chk("R9 pll_en", int'(pll_en), int'(m_act_pll != 0 || tp != 0));
            chk("R9 internal enables", int'({piosc_en, lfiosc_en}), 3);
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(posedge clk); #1 rst = 1'b1;
        step(2);
        rst = 1'b0;
    endtask

    task automatic wr_run(bit p, int osc, int ref_code, int dv);
        @(posedge clk); #1;
        run_wr = 1'b1; run_use_pll = p; run_osc_src = 3'(osc);
        run_pll_src = 3'(ref_code); run_div = DIV_W'(dv);
        step(1);
        run_wr = 1'b0;
    endtask

    task automatic wr_deep(bit p, int osc, int ref_code, int dv);
        @(posedge clk); #1;
        deep_wr = 1'b1; deep_use_pll = p; deep_osc_src = 3'(osc);
        deep_pll_src = 3'(ref_code); deep_div = DIV_W'(dv);
        step(1);
        deep_wr = 1'b0;
    endtask

    task automatic wait_done(string tag);
        bit seen = 1'b0;
        for (int i = 0; i < 200 && !seen; i++) begin
            @(negedge clk);
            if (switch_done) seen = 1'b1;
        end
        chk(tag, int'(seen), 1);
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        started = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 active_src", int'(active_src), 0);
        chk("R1 active_pll", int'(active_pll), 0);
        chk("R1 osc enables", int'({piosc_en, lfiosc_en, mosc_en, rtc_en, pll_en}), 5'b11000);
        chk("R1 clk_en", int'(clk_en), 1);
        chk("R1 cfg_err", int'(cfg_err), 0);

        // R2 direct source codes
        wr_run(0, 3, 0, 0); step(3); @(negedge clk);
        chk("R2 main osc select", int'(clk_sel), 5'b00100);
        wr_run(0, 2, 0, 0); step(3); @(negedge clk);
        chk("R2 low-freq select", int'(clk_sel), 5'b00010);
        wr_run(0, 4, 0, 0); step(3); @(negedge clk);
        chk("R2 rtc select", int'(clk_sel), 5'b01000);

        // R4 invalid direct codes, R10 stickiness
        wr_run(0, 5, 0, 0); step(3); @(negedge clk);
        chk("R4 err after bad code", int'(cfg_err), 1);
        chk("R4 source kept", int'(active_src), 4);
        wr_run(0, 1, 0, 0); step(3); @(negedge clk);
        chk("R4 source kept code1", int'(active_src), 4);
        wr_run(0, 0, 0, 0); step(3); @(negedge clk);
        chk("R10 err stays", int'(cfg_err), 1);
        chk("R10 legal write applied", int'(active_src), 0);

        // R8 divisor
        do_reset();
        wr_run(0, 0, 0, 3); step(8);
        begin
            int ones = 0;
            for (int i = 0; i < 16; i++) begin
                @(negedge clk);
                if (clk_en) ones++;
            end
            chk("R8 one enable in four", ones, 4);
        end

        // R6 boundary switch with a divided clock, one-cycle pulse
        wr_run(0, 3, 0, 3);
        wait_done("R6 switch seen");
        @(negedge clk);
        chk("R6 pulse one cycle", int'(switch_done), 0);
        chk("R6 new source", int'(active_src), 3);

        // R5 PLL waits for lock
        pll_lock = 1'b0;
        wr_run(1, 0, 3, 1); step(12); @(negedge clk);
        chk("R5 still on old source", int'(active_pll), 0);
        chk("R5 pll powered while waiting", int'(pll_en), 1);
        chk("R9 main osc on as reference", int'(mosc_en), 1);
        pll_lock = 1'b1;
        step(10); @(negedge clk);
        chk("R5 pll live after lock", int'(active_pll), 1);
        chk("R5 pll clk_sel", int'(clk_sel), 5'b10000);

        // R3 PLL reference codes
        wr_run(1, 0, 2, 0); step(4); @(negedge clk);
        chk("R3 low-freq ref rejected", int'(cfg_err), 1);
        chk("R3 ref kept", int'(active_src), 3);
        do_reset();
        wr_run(1, 0, 4, 0); step(4); @(negedge clk);
        chk("R3 rtc ref rejected", int'(cfg_err), 1);
        chk("R3 no pll after reject", int'(active_pll), 0);
        do_reset();
        wr_run(1, 0, 0, 0); step(4); @(negedge clk);
        chk("R3 precision ref accepted", int'(active_pll), 1);
        chk("R3 precision ref code", int'(active_src), 0);
        chk("R3 no err", int'(cfg_err), 0);

        // R7 deep-sleep register
        do_reset();
        pll_lock = 1'b0;
        wr_deep(0, 4, 0, 2); step(4); @(negedge clk);
        chk("R7 run mode ignores deep", int'(active_src), 0);
        chk("R9 rtc off when only deep wants it", int'(rtc_en), 0);
        @(posedge clk); #1 deep_sleep = 1'b1;
        wait_done("R7 entry switch");
        chk("R7 deep source", int'(active_src), 4);
        wr_run(0, 3, 0, 0); step(6); @(negedge clk);
        chk("R7 run write ignored in deep", int'(active_src), 4);
        @(posedge clk); #1 deep_sleep = 1'b0;
        wait_done("R7 exit switch");
        chk("R7 back to run source", int'(active_src), 3);

        // Deep-sleep PLL selection waiting for lock, with mode flips
        wr_deep(1, 0, 3, 5); step(3);
        @(posedge clk); #1 deep_sleep = 1'b1;
        step(15); @(negedge clk);
        chk("R5 deep pll waits", int'(active_pll), 0);
        pll_lock = 1'b1;
        step(12); @(negedge clk);
        chk("R5 deep pll live", int'(active_pll), 1);
        @(posedge clk); #1 deep_sleep = 1'b0;
        step(12); @(negedge clk);
        chk("R7 run source after exit", int'(active_src), 3);
        chk("R7 pll off after exit", int'(active_pll), 0);

        step(4);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #400000;
        n_checks++;
        n_errors++;
        $display("FAIL R1 watchdog: actual 1 expected 0 (run did not finish)");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule